// File: doc/BRIEF.md
# PWM Dead-Band Generator

This block sits between a PWM waveform generator and the gate drivers of a half bridge. It takes two raw PWM levels, A and B, and builds two outputs with programmable dead time. One path holds back only the low-to-high transitions of the signal it is fed and produces RED. The other path holds back only the high-to-low transitions and produces FED. Each hold-back is counted in time-base ticks, and a tick is any clock cycle with the tick enable high.

Three 2-bit mode fields set up the datapath. The input mode picks the source of each path. The polarity field picks whether each path is inverted. The output mode picks, for each output, its path or the raw input. With both paths fed from A, RED not inverted, FED inverted and both outputs taken from their paths, the block gives an active-high complementary pair. Both outputs are then low for a gap around every edge of A.

All pins are plain level signals, sampled on every clock. There is no streaming transfer, so there is no valid/ready handshake and no back-pressure. A new delay count or mode value reaches a path only at an input edge of that path, so a change made while a pulse is in flight cannot chop the pulse.

Top module: `db_deadband_gen`

## Requirements
- R1: While `rst_n` is low, both outputs are low. After reset, each path is in pass-through from input A with no inversion until it adopts the programmed mode (R11).
- R2: When a path's adopted output-mode bit is 0, its output equals the matching raw input one clock later. The polarity and delay settings then have no effect on that output.
- R3: The RED path delays rising edges. Say its source is first sampled high at clock k, and `tb_en` is held high. RED goes high after clock k+`rise_dly`, so it is seen high in the (`rise_dly`+1)-th cycle. A falling edge of the source reaches RED after the next clock.
- R4: The FED path delays falling edges by `fall_dly` ticks, timed in the same way as R3. A rising edge of its source reaches FED after the next clock.
- R5: If a source pulse ends before its delay has expired, the delayed transition is dropped. The delayed level is not reached for that pulse.
- R6: A delay of 0 passes the delayed edge after one clock, the same latency as pass-through.
- R7: A pending delay counts down only on cycles with `tb_en` high. The clock that first samples the edge loads the count and is not itself counted.
- R8: Input mode bit 0 picks the RED source and bit 1 picks the FED source, with 0 meaning A and 1 meaning B. The value 2'b00 feeds both paths from A. An input that feeds no path has no effect on the outputs.
- R9: Polarity bit 0 inverts RED and bit 1 inverts FED. The value 2'b10 is active-high complementary.
- R10: When output mode bit 0 is 1, output A comes from the RED path, and otherwise it comes from raw A. When bit 1 is 1, output B comes from the FED path, and otherwise from raw B. The value 2'b11 enables both paths.
- R11: A delay count is captured when its delayed edge begins, so later writes do not change a pending edge. A path adopts new input-mode, polarity and output-mode bits only on a clock that samples an edge of its current source.
- R12: With both paths fed from A, polarity 2'b10 and output mode 2'b11, the two outputs are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tb_en | input | 1 | Time-base tick enable for the delay counters |
| pwm_a_in | input | 1 | Raw PWM input A |
| pwm_b_in | input | 1 | Raw PWM input B |
| rise_dly | input | DLY_W | Rising-edge delay in ticks |
| fall_dly | input | DLY_W | Falling-edge delay in ticks |
| in_mode | input | 2 | Source select per path (bit 0 RED, bit 1 FED; 0 = A, 1 = B) |
| pol_sel | input | 2 | Inversion per path (bit 0 RED, bit 1 FED) |
| out_mode | input | 2 | Output source (bit 0 for A, bit 1 for B; 1 = delayed path) |
| pwm_a_out | output | 1 | Dead-band output A |
| pwm_b_out | output | 1 | Dead-band output B |

## Verification
The hardest state to reach is a path that has switched its source while a delay is pending. An edge on the old source both adopts the new selection and starts a count. The very next clock then sees the other input as the source, and it may sit at the opposite level. The bench reaches this state by programming a new input mode and then toggling A. Only after that does it drive B, and it checks that A changes are ignored. It also rewrites the delay count and polarity while a pulse is pending, to show that they take hold only at the next source edge.

// File: rtl/db_pkg.sv
package db_pkg;
  typedef enum logic {
    SRC_A = 1'b0,
    SRC_B = 1'b1
  } src_e;

  typedef struct packed {
    src_e sel;
    logic inv;
    logic use_dly;
  } path_cfg_t;

  localparam int NPATH     = 2;
  localparam int PATH_RISE = 0;
  localparam int PATH_FALL = 1;
endpackage

// File: rtl/db_edge_delay.sv
module db_edge_delay #(
  parameter int   DLY_W       = 10,
  parameter logic DELAYED_LVL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tb_en,
  input  logic             src_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             lvl_o,
  output logic             edge_o
);
  localparam logic [DLY_W-1:0] LAST_TICK = DLY_W'(1);

  logic             prev;
  logic             busy;
  logic [DLY_W-1:0] cnt;

  assign edge_o = src_i ^ prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev  <= 1'b0;
      busy  <= 1'b0;
      cnt   <= '0;
      lvl_o <= 1'b0;
    end else begin
      prev <= src_i;
      if (src_i != DELAYED_LVL) begin
        // undelayed direction: follow at once, drop any pending edge
        lvl_o <= src_i;
        busy  <= 1'b0;
      end else if (prev != DELAYED_LVL) begin
        // delayed edge begins: capture the count now
        if (dly_i == '0) begin
          lvl_o <= DELAYED_LVL;
          busy  <= 1'b0;
        end else begin
          busy <= 1'b1;
          cnt  <= dly_i;
        end
      end else if (busy && tb_en) begin
        if (cnt == LAST_TICK) begin
          lvl_o <= DELAYED_LVL;
          busy  <= 1'b0;
        end
        cnt <= cnt - LAST_TICK;
      end
    end
  end
endmodule

// File: rtl/db_path.sv
module db_path
  import db_pkg::*;
#(
  parameter int   DLY_W       = 10,
  parameter logic DELAYED_LVL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tb_en,
  input  logic             a_in,
  input  logic             b_in,
  input  logic [DLY_W-1:0] dly,
  input  path_cfg_t        prog,
  output path_cfg_t        act_o,
  output logic             src_o,
  output logic             lvl_o,
  output logic             pol_o
);
  path_cfg_t act;
  logic      edge_seen;

  assign src_o = (act.sel == SRC_B) ? b_in : a_in;

  db_edge_delay #(
    .DLY_W      (DLY_W),
    .DELAYED_LVL(DELAYED_LVL)
  ) u_dly (
    .clk   (clk),
    .rst_n (rst_n),
    .tb_en (tb_en),
    .src_i (src_o),
    .dly_i (dly),
    .lvl_o (lvl_o),
    .edge_o(edge_seen)
  );

  // mode bits move into the path only at an edge of its own source
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act <= '0;
    end else if (edge_seen) begin
      act <= prog;
    end
  end

  assign act_o = act;
  assign pol_o = lvl_o ^ act.inv;
endmodule

// File: rtl/db_deadband_gen.sv
module db_deadband_gen
  import db_pkg::*;
#(
  parameter int DLY_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tb_en,
  input  logic             pwm_a_in,
  input  logic             pwm_b_in,
  input  logic [DLY_W-1:0] rise_dly,
  input  logic [DLY_W-1:0] fall_dly,
  input  logic [1:0]       in_mode,
  input  logic [1:0]       pol_sel,
  input  logic [1:0]       out_mode,
  output logic             pwm_a_out,
  output logic             pwm_b_out
);
  logic [NPATH-1:0] raw_q;
  logic [NPATH-1:0] path_src;
  logic [NPATH-1:0] dly_lvl;
  logic [NPATH-1:0] path_pol;
  logic [NPATH-1:0] path_out;
  logic [NPATH-1:0] act_sel;
  logic [NPATH-1:0] act_inv;
  logic [NPATH-1:0] act_use;
  logic [DLY_W-1:0] dly_set [NPATH];

  assign dly_set[PATH_RISE] = rise_dly;
  assign dly_set[PATH_FALL] = fall_dly;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= '0;
    end else begin
      raw_q <= {pwm_b_in, pwm_a_in};
    end
  end

  for (genvar p = 0; p < NPATH; p++) begin : g_path
    path_cfg_t prog;
    path_cfg_t act;

    assign prog.sel     = src_e'(in_mode[p]);
    assign prog.inv     = pol_sel[p];
    assign prog.use_dly = out_mode[p];

    db_path #(
      .DLY_W      (DLY_W),
      .DELAYED_LVL((p == PATH_RISE) ? 1'b1 : 1'b0)
    ) u_path (
      .clk  (clk),
      .rst_n(rst_n),
      .tb_en(tb_en),
      .a_in (pwm_a_in),
      .b_in (pwm_b_in),
      .dly  (dly_set[p]),
      .prog (prog),
      .act_o(act),
      .src_o(path_src[p]),
      .lvl_o(dly_lvl[p]),
      .pol_o(path_pol[p])
    );

    assign act_sel[p]  = act.sel;
    assign act_inv[p]  = act.inv;
    assign act_use[p]  = act.use_dly;
    assign path_out[p] = act.use_dly ? path_pol[p] : raw_q[p];
  end

  assign pwm_a_out = path_out[PATH_RISE];
  assign pwm_b_out = path_out[PATH_FALL];
endmodule

// File: rtl/db_deadband_chk.sv
module db_deadband_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tb_en,
  input logic       pwm_a_in,
  input logic       pwm_b_in,
  input logic       pwm_a_out,
  input logic       pwm_b_out,
  input logic [1:0] path_src,
  input logic [1:0] dly_lvl,
  input logic [1:0] act_sel,
  input logic [1:0] act_inv,
  input logic [1:0] act_use
);
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R2: pass-through output tracks its raw input one clock later
  p_bypass_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !act_use[0]) |-> (pwm_a_out == $past(pwm_a_in)));

  p_bypass_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !act_use[1]) |-> (pwm_b_out == $past(pwm_b_in)));

  // R3: a low RED source drops RED on the next clock
  p_fast_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !path_src[0]) |=> !dly_lvl[0]);

  // R4: a high FED source raises FED on the next clock
  p_fast_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && path_src[1]) |=> dly_lvl[1]);

  // R7: without a tick a pending RED edge does not complete
  p_tick_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !tb_en && path_src[0] && $past(path_src[0]) && !dly_lvl[0])
      |=> !dly_lvl[0]);

  // R12: complementary outputs never overlap
  p_dead_gap_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && act_sel == 2'b00 && $stable(act_sel) && act_inv == 2'b10 &&
     act_use == 2'b11) |-> !(pwm_a_out && pwm_b_out));
endmodule

bind db_deadband_gen db_deadband_chk u_chk (.*);

// File: tb/db_deadband_gen_tb_top.sv
`timescale 1ns/1ps
module db_deadband_gen_tb_top;
  localparam int DLY_W = 10;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             tb_en = 1'b1;
  logic             pwm_a_in = 1'b0;
  logic             pwm_b_in = 1'b0;
  logic [DLY_W-1:0] rise_dly = 10'd5;
  logic [DLY_W-1:0] fall_dly = 10'd3;
  logic [1:0]       in_mode = 2'b00;
  logic [1:0]       pol_sel = 2'b00;
  logic [1:0]       out_mode = 2'b00;
  logic             pwm_a_out;
  logic             pwm_b_out;

  db_deadband_gen #(.DLY_W(DLY_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .tb_en(tb_en),
    .pwm_a_in(pwm_a_in), .pwm_b_in(pwm_b_in),
    .rise_dly(rise_dly), .fall_dly(fall_dly),
    .in_mode(in_mode), .pol_sel(pol_sel), .out_mode(out_mode),
    .pwm_a_out(pwm_a_out), .pwm_b_out(pwm_b_out)
  );

  always #10 clk = ~clk;

  int    n_cmp = 0;
  int    n_bad = 0;
  int    gap_hits = 0;
  bit    gap_on = 0;
  bit    done = 0;
  string tag = "R1";

  // behavioural reference: per path level, pending ticks and adopted mode
  int m_q[2], m_prev[2], m_left[2], m_sel[2], m_inv[2], m_use[2], m_raw[2];
  int m_src, m_goal, m_d;
  logic [1:0] exp_o = 2'b00;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < 2; p++) begin
        m_q[p] = 0; m_prev[p] = 0; m_left[p] = -1;
        m_sel[p] = 0; m_inv[p] = 0; m_use[p] = 0; m_raw[p] = 0;
      end
    end else begin
      for (int p = 0; p < 2; p++) begin
        m_src  = (m_sel[p] != 0) ? int'(pwm_b_in) : int'(pwm_a_in);
        m_goal = (p == 0) ? 1 : 0;
        m_d    = (p == 0) ? int'(rise_dly) : int'(fall_dly);
        if (m_src != m_prev[p]) begin
          m_sel[p] = int'(in_mode[p]);
          m_inv[p] = int'(pol_sel[p]);
          m_use[p] = int'(out_mode[p]);
        end
        if (m_src != m_goal) begin
          m_q[p] = m_src; m_left[p] = -1;
        end else if (m_prev[p] != m_goal) begin
          if (m_d == 0) begin m_q[p] = m_goal; m_left[p] = -1; end
          else m_left[p] = m_d;
        end else if (m_left[p] > 0 && tb_en) begin
          m_left[p] = m_left[p] - 1;
          if (m_left[p] == 0) begin m_q[p] = m_goal; m_left[p] = -1; end
        end
        m_prev[p] = m_src;
      end
      m_raw[0] = int'(pwm_a_in);
      m_raw[1] = int'(pwm_b_in);
    end
    for (int p = 0; p < 2; p++)
      exp_o[p] = (m_use[p] != 0) ? logic'(m_q[p] ^ m_inv[p]) : logic'(m_raw[p]);
  end

  always @(negedge clk) begin
    if (!done) begin
      n_cmp++;
      if (pwm_a_out !== exp_o[0]) begin
        n_bad++;
        $display("FAIL %s model out A actual=%0b expected=%0b", tag, pwm_a_out, exp_o[0]);
      end
      n_cmp++;
      if (pwm_b_out !== exp_o[1]) begin
        n_bad++;
        $display("FAIL %s model out B actual=%0b expected=%0b", tag, pwm_b_out, exp_o[1]);
      end
      if (gap_on && pwm_a_out && pwm_b_out) gap_hits++;
    end
  end

  task automatic chk(input string req, input logic act, input logic expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s directed actual=%0b expected=%0b", req, act, expv);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    // R1: reset holds outputs low even with inputs high
    pwm_a_in = 1'b1; pwm_b_in = 1'b1;
    wait_n(3);
    chk("R1", pwm_a_out, 1'b0);
    chk("R1", pwm_b_out, 1'b0);
    pwm_a_in = 1'b0; pwm_b_in = 1'b0;
    wait_n(1);
    rst_n = 1'b1;
    wait_n(2);

    // R2: pass-through, polarity and delay programmed but no effect
    tag = "R2"; pol_sel = 2'b11; out_mode = 2'b00;
    pwm_a_in = 1'b1; wait_n(1); chk("R2", pwm_a_out, 1'b1); chk("R2", pwm_b_out, 1'b0);
    pwm_b_in = 1'b1; wait_n(1); chk("R2", pwm_b_out, 1'b1);
    pwm_a_in = 1'b0; wait_n(1); chk("R2", pwm_a_out, 1'b0);
    pwm_b_in = 1'b0; wait_n(1); chk("R2", pwm_b_out, 1'b0);
    wait_n(10);

    // R3 R4 R9 R10: active-high complementary, rise 5, fall 3
    tag = "R10"; gap_on = 1;
    pol_sel = 2'b10; out_mode = 2'b11; in_mode = 2'b00;
    pwm_a_in = 1'b1;
    wait_n(1); chk("R9", pwm_a_out, 1'b0); chk("R9", pwm_b_out, 1'b0);
    wait_n(4); chk("R3", pwm_a_out, 1'b0);
    wait_n(1); chk("R3", pwm_a_out, 1'b1); chk("R10", pwm_b_out, 1'b0);
    wait_n(2);
    pwm_a_in = 1'b0;
    wait_n(1); chk("R3", pwm_a_out, 1'b0); chk("R4", pwm_b_out, 1'b0);
    wait_n(2); chk("R4", pwm_b_out, 1'b0);
    wait_n(1); chk("R4", pwm_b_out, 1'b1);
    wait_n(6);

    // R5: two-cycle pulse shorter than the 5-tick delay
    tag = "R5";
    pwm_a_in = 1'b1; wait_n(2); pwm_a_in = 1'b0;
    for (int j = 0; j < 10; j++) begin
      wait_n(1); chk("R5", pwm_a_out, 1'b0);
    end

    // R6: zero delay
    tag = "R6"; rise_dly = 10'd0;
    pwm_a_in = 1'b1; wait_n(1); chk("R6", pwm_a_out, 1'b1);
    pwm_a_in = 1'b0; wait_n(1); chk("R6", pwm_a_out, 1'b0);
    wait_n(6);

    // R7: ticks stopped, then 4 ticks
    tag = "R7"; rise_dly = 10'd4;
    wait_n(1);
    pwm_a_in = 1'b1; tb_en = 1'b0;
    for (int j = 0; j < 6; j++) begin
      wait_n(1); chk("R7", pwm_a_out, 1'b0);
    end
    tb_en = 1'b1;
    wait_n(3); chk("R7", pwm_a_out, 1'b0);
    wait_n(1); chk("R7", pwm_a_out, 1'b1);
    pwm_a_in = 1'b0;
    wait_n(8);
    gap_on = 0;
    chk("R12", logic'(gap_hits == 0), 1'b1);

    // R8: move both paths to B, adopted at an edge of A
    tag = "R8"; rise_dly = 10'd5; in_mode = 2'b11;
    pwm_a_in = 1'b1;
    wait_n(12);
    pwm_a_in = 1'b0;
    for (int j = 0; j < 4; j++) begin
      wait_n(1); chk("R8", pwm_a_out, 1'b0); chk("R8", pwm_b_out, 1'b1);
    end
    pwm_b_in = 1'b1;
    wait_n(1); chk("R8", pwm_b_out, 1'b0); chk("R8", pwm_a_out, 1'b0);
    wait_n(4); chk("R8", pwm_a_out, 1'b0);
    wait_n(1); chk("R8", pwm_a_out, 1'b1);
    wait_n(2);

    // R11: count captured at edge start; polarity waits for an edge
    tag = "R11";
    pwm_b_in = 1'b0;
    wait_n(8);
    rise_dly = 10'd6; pwm_b_in = 1'b1;
    wait_n(1); rise_dly = 10'd2;
    wait_n(5); chk("R11", pwm_a_out, 1'b0);
    wait_n(1); chk("R11", pwm_a_out, 1'b1);
    pol_sel = 2'b00;
    wait_n(4); chk("R11", pwm_b_out, 1'b0);
    pwm_b_in = 1'b0;
    wait_n(1); chk("R11", pwm_b_out, 1'b1); chk("R11", pwm_a_out, 1'b0);
    wait_n(3); chk("R11", pwm_b_out, 1'b0);
    wait_n(4);

    finish_run();
  end
endmodule